// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit gathers the event and level sources of a packet-mode I2C controller into one interrupt request line. Six event sources are captured as sticky flags: single-packet done, all-packets done, transmit overflow, receive underflow, missing acknowledge and lost arbitration. Two FIFO data-request levels are shown live beside them. A mask register chooses which sources may raise the request. Single-packet done is the exception: it always raises the request, whatever the mask holds.

Software reaches the unit through a plain address, write-enable and data port. Reads are combinational from the current state. Writes take effect at the next clock edge. An event flag is acknowledged by writing a one to its position in the status register.

Top module: `irq_status_mask_unit`

## Requirements
- R1: After reset the mask register reads 0x00, every sticky status flag reads 0 and `irq_o` is low.
- R2: A one-cycle pulse on an event input sets its status bit, and the bit stays set. The positions are: packet done bit 7, all done bit 6, TX overflow bit 5, RX underflow bit 4, no-acknowledge bit 3, arbitration lost bit 2.
- R3: Writing the status register (offset 0x068) clears each sticky bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 1 equals the TX data-request level and bit 0 the RX data-request level at all times. Writes to these two bits have no effect.
- R6: The mask register (offset 0x064) reads back bits 7:0 as last written. Bits above 7 read 0.
- R7: `irq_o` is registered. After each clock edge it equals the OR over bits 7:0 of (status AND mask), ORed with status bit 7. A set but masked source therefore leaves it low.
- R8: Status bit 7 drives `irq_o` high even while mask bit 7 is 0. Clearing the bit drops the request again.
- R9: Reads of any offset other than 0x064 and 0x068 return 0. Writes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| ev_pkt_done_i | input | 1 | Single-packet-done pulse |
| ev_all_done_i | input | 1 | All-packets-done pulse |
| ev_tx_ovf_i | input | 1 | TX FIFO overflow pulse |
| ev_rx_unf_i | input | 1 | RX FIFO underflow pulse |
| ev_nack_i | input | 1 | Missing-acknowledge pulse |
| ev_arb_lost_i | input | 1 | Arbitration-lost pulse |
| lvl_tx_req_i | input | 1 | TX FIFO data-request level |
| lvl_rx_req_i | input | 1 | RX FIFO data-request level |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume that event inputs are single-cycle pulses that a clock edge samples cleanly. They also assume that register writes last exactly one cycle and carry a stable address and data. The stimulus changes every input only on the falling edge. Each pulse and each write is held for exactly one cycle, and the FIFO levels are moved only between register accesses. One step drives an event pulse and a clearing write to the same bit in the same cycle on purpose. This exercises the set-over-clear priority within those assumptions.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
    localparam int N_SRC    = 8;
    localparam int N_LVL    = 2;
    localparam int N_STICKY = N_SRC - N_LVL;

    localparam int BIT_PKT_DONE = 7;
    localparam int BIT_ALL_DONE = 6;
    localparam int BIT_TX_OVF   = 5;
    localparam int BIT_RX_UNF   = 4;
    localparam int BIT_NACK     = 3;
    localparam int BIT_ARB_LOST = 2;
    localparam int BIT_TX_REQ   = 1;
    localparam int BIT_RX_REQ   = 0;

    typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flags_o
);
    typedef struct packed {
        logic [WIDTH-1:0] flags;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // Each flag: clear is applied first, so a set in the same cycle wins.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDTH; i++) begin
            if (clr_i[i]) st_d.flags[i] = 1'b0;
            if (set_i[i]) st_d.flags[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] mask_o
);
    typedef struct packed {
        logic [WIDTH-1:0] mask;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int WIDTH     = 8,
    parameter int FORCE_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_nx_i,
    input  logic [WIDTH-1:0] mask_nx_i,
    output logic             irq_o
);
    typedef struct packed {
        logic irq;
    } line_state_t;

    line_state_t st_d, st_q;

    always_comb begin
        st_d.irq = (|(status_nx_i & mask_nx_i)) | status_nx_i[FORCE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
endmodule

// File: rtl/irq_status_mask_unit.sv
module irq_status_mask_unit
    import irq_unit_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] MASK_OFS = 12'h064,
    parameter logic [11:0] STAT_OFS = 12'h068
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              ev_pkt_done_i,
    input  logic              ev_all_done_i,
    input  logic              ev_tx_ovf_i,
    input  logic              ev_rx_unf_i,
    input  logic              ev_nack_i,
    input  logic              ev_arb_lost_i,
    input  logic              lvl_tx_req_i,
    input  logic              lvl_rx_req_i,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    typedef struct packed {
        logic          hit_mask;
        logic          hit_stat;
        logic [N_STICKY-1:0] set;
        logic [N_STICKY-1:0] clr;
        src_vec_t      status_nx;
        src_vec_t      mask_nx;
    } decode_t;

    decode_t dec;

    logic [N_STICKY-1:0] stat_sticky;
    src_vec_t            mask_q;
    src_vec_t            status_view;
    logic [N_LVL-1:0]    levels;

    assign levels = {lvl_tx_req_i, lvl_rx_req_i};

    always_comb begin
        dec.hit_mask = (reg_addr_i == A_MASK);
        dec.hit_stat = (reg_addr_i == A_STAT);
        dec.set = {ev_pkt_done_i, ev_all_done_i, ev_tx_ovf_i,
                   ev_rx_unf_i, ev_nack_i, ev_arb_lost_i};
        dec.clr = (reg_wr_i && dec.hit_stat) ? reg_wdata_i[N_SRC-1:N_LVL] : '0;
        dec.status_nx = {(stat_sticky & ~dec.clr) | dec.set, levels};
        dec.mask_nx = (reg_wr_i && dec.hit_mask) ? reg_wdata_i[N_SRC-1:0] : mask_q;
    end

    irq_sticky_bank #(.WIDTH(N_STICKY)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (dec.set),
        .clr_i   (dec.clr),
        .flags_o (stat_sticky)
    );

    irq_mask_reg #(.WIDTH(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i && dec.hit_mask),
        .wdata_i (reg_wdata_i[N_SRC-1:0]),
        .mask_o  (mask_q)
    );

    irq_line_gen #(.WIDTH(N_SRC), .FORCE_BIT(BIT_PKT_DONE)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .status_nx_i (dec.status_nx),
        .mask_nx_i   (dec.mask_nx),
        .irq_o       (irq_o)
    );

    assign status_view = {stat_sticky, levels};

    always_comb begin
        reg_rdata_o = '0;
        if (dec.hit_mask)      reg_rdata_o[N_SRC-1:0] = mask_q;
        else if (dec.hit_stat) reg_rdata_o[N_SRC-1:0] = status_view;
    end
endmodule

// File: rtl/irq_status_mask_chk.sv
module irq_status_mask_chk #(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32,
    parameter logic [11:0] MASK_OFS = 12'h064,
    parameter logic [11:0] STAT_OFS = 12'h068
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              ev_pkt_done_i,
    input logic              ev_tx_ovf_i,
    input logic              ev_nack_i,
    input logic              ev_arb_lost_i,
    input logic              lvl_tx_req_i,
    input logic              lvl_rx_req_i,
    input logic              irq_o,
    input logic [5:0]        stat_sticky
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    assert_arb_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost_i |=> stat_sticky[0]);

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[5] && !ev_tx_ovf_i)
        |=> !stat_sticky[3]);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nack_i && reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[3])
        |=> stat_sticky[1]);

    assert_level_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == A_STAT) |-> (reg_rdata_o[1:0] == {lvl_tx_req_i, lvl_rx_req_i}));

    assert_pkt_unmaskable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pkt_done_i |=> irq_o);

    assert_other_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i != A_STAT && reg_addr_i != A_MASK) |-> (reg_rdata_o == '0));

    assert_quiet_when_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_sticky == '0 && !ev_pkt_done_i && !ev_tx_ovf_i && !ev_nack_i
         && !ev_arb_lost_i && !lvl_tx_req_i && !lvl_rx_req_i
         && $past(stat_sticky) == '0)
        |-> (irq_o == 1'b0 || $past(irq_o) == 1'b1 || $past(stat_sticky) != '0));
endmodule

bind irq_status_mask_unit irq_status_mask_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_OFS(MASK_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr_i    (reg_addr_i),
    .reg_wr_i      (reg_wr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .ev_pkt_done_i (ev_pkt_done_i),
    .ev_tx_ovf_i   (ev_tx_ovf_i),
    .ev_nack_i     (ev_nack_i),
    .ev_arb_lost_i (ev_arb_lost_i),
    .lvl_tx_req_i  (lvl_tx_req_i),
    .lvl_rx_req_i  (lvl_rx_req_i),
    .irq_o         (irq_o),
    .stat_sticky   (stat_sticky)
);

// File: tb/irq_status_mask_unit_bench.sv
module irq_status_mask_unit_bench;
    localparam int CLK_P = 10;
    localparam logic [11:0] A_MASK = 12'h064;
    localparam logic [11:0] A_STAT = 12'h068;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_pkt = 0, ev_all = 0, ev_ovf = 0, ev_unf = 0, ev_nack = 0, ev_arb = 0;
    logic        lvl_tx = 0, lvl_rx = 0;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    irq_status_mask_unit u_irq_status_mask_unit (
        .clk(clk), .rst_n(rst_n),
        .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .ev_pkt_done_i(ev_pkt), .ev_all_done_i(ev_all), .ev_tx_ovf_i(ev_ovf),
        .ev_rx_unf_i(ev_unf), .ev_nack_i(ev_nack), .ev_arb_lost_i(ev_arb),
        .lvl_tx_req_i(lvl_tx), .lvl_rx_req_i(lvl_rx),
        .irq_o(irq)
    );

    // Monitor: a quarter period after each rising edge, compare pending items.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: %s actual=%h expected=%h",
                             it.tag, it.is_irq ? "irq" : "rdata", act, it.exp);
                end
            end
        end
    end

    // Driver tasks: entered on a falling edge, leave on the next one.
    task automatic idle();
        reg_wr = 0; {ev_pkt, ev_all, ev_ovf, ev_unf, ev_nack, ev_arb} = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1; reg_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse(input logic [5:0] ev);
        {ev_pkt, ev_all, ev_ovf, ev_unf, ev_nack, ev_arb} = ev;
        @(negedge clk);
        idle();
    endtask

    task automatic chk_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        idle();
        reg_addr = a;
        it.is_irq = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        idle();
        it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk_rd(A_MASK, 32'h0, "R1");
        chk_rd(A_STAT, 32'h0, "R1");
        chk_irq(1'b0, "R1");
        // R2 no-ack pulse sets bit 3, masked so R7 keeps irq low
        pulse(6'b000010);
        chk_rd(A_STAT, 32'h08, "R2");
        chk_irq(1'b0, "R7");
        // R7 enabling the mask raises irq; R6 readback
        wr(A_MASK, 32'h08);
        chk_irq(1'b1, "R7");
        chk_rd(A_MASK, 32'h08, "R6");
        wr(A_MASK, 32'hFFFF_FFFF);
        chk_rd(A_MASK, 32'hFF, "R6");
        // R3 zero write keeps, one write clears
        wr(A_STAT, 32'h0);
        chk_rd(A_STAT, 32'h08, "R3");
        wr(A_STAT, 32'h08);
        chk_rd(A_STAT, 32'h00, "R3");
        chk_irq(1'b0, "R3");
        // R4 set wins over clear in the same cycle (bit 2)
        ev_arb = 1; wr(A_STAT, 32'h04);
        chk_rd(A_STAT, 32'h04, "R4");
        wr(A_STAT, 32'h04);
        chk_rd(A_STAT, 32'h00, "R4");
        // R2 every event bit, mask off: R8 bit 7 still raises irq
        wr(A_MASK, 32'h0);
        pulse(6'b111111);
        chk_rd(A_STAT, 32'hFC, "R2");
        chk_irq(1'b1, "R8");
        wr(A_STAT, 32'h80);
        chk_rd(A_STAT, 32'h7C, "R3");
        chk_irq(1'b0, "R7");
        wr(A_STAT, 32'hFF);
        chk_rd(A_STAT, 32'h00, "R3");
        // R5 level bits mirror live levels, writes ignored
        lvl_tx = 1;
        chk_rd(A_STAT, 32'h02, "R5");
        wr(A_STAT, 32'h03);
        chk_rd(A_STAT, 32'h02, "R5");
        chk_irq(1'b0, "R7");
        wr(A_MASK, 32'h02);
        chk_irq(1'b1, "R7");
        lvl_tx = 0; lvl_rx = 1;
        chk_rd(A_STAT, 32'h01, "R5");
        chk_irq(1'b0, "R7");
        lvl_rx = 0;
        // R9 other offsets read zero, writes there touch nothing
        wr(12'h060, 32'hFF);
        chk_rd(12'h060, 32'h0, "R9");
        chk_rd(12'h000, 32'h0, "R9");
        chk_rd(A_MASK, 32'h02, "R9");
        chk_rd(A_STAT, 32'h00, "R9");
        // R8 packet done with empty mask, then cleared
        wr(A_MASK, 32'h0);
        pulse(6'b100000);
        chk_irq(1'b1, "R8");
        wr(A_STAT, 32'h80);
        chk_irq(1'b0, "R8");
        @(negedge clk);
        finished = 1;
        finish_run();
    end
endmodule